// File: doc/BRIEF.md
# Prescaled Interval Timer with Interrupt

This block is an 8-bit interval timer that sits on a simple synchronous register bus. Software writes a start value and picks a prescale ratio of 1, 8, 64 or 1024 with the same write. An internal counter, wide enough to hold the start value scaled by the largest ratio, then counts down once per system clock. The value software reads back is the counter divided by the active ratio.

When the counter counts down past zero, a timer flag is set. The timer then drops to counting the raw clock from 0xFF downward, so software can read how many clocks have passed since expiry. Reading the timer after expiry brings the written ratio back into force, and the interrupt-enable bit is updated on every timer access. The interrupt request is the timer flag gated by that enable bit.

Top module: `tickTimer`

## Requirements
- R1: After reset, a timer read returns 0xFF, a status read returns 0x00, and `irq` is low.
- R2: A timer write (`wrEn` with `addr[2]` and `addr[4]` set) picks a shift from `addr[1:0]`: 0→0, 1→3, 2→6, 3→10. It loads the counter with `wrData` shifted left by that amount and sets both the active shift and the written shift to it. A timer read in the next cycle returns `wrData`.
- R3: A write with `addr[4]` clear, or with `addr[2]` clear, has no effect on the timer.
- R4: On every clock without a timer write or a restoring read, a non-zero counter decrements by one. A counter that reaches zero does not set the flag.
- R5: The first clock after a write that finds the counter at zero sets the timer flag. That is the (`wrData` << shift) + 1-th clock edge after the write edge.
- R6: On that clock the counter becomes 0xFF and the active shift becomes 0. It keeps counting down one per clock, and each later pass through zero sets the flag again and reloads 0xFF.
- R7: A timer read (`rdEn`, `addr[2]` set, `addr[0]` clear) returns the counter shifted right by the active shift. On any timer access the interrupt enable takes `addr[3]` and the flag is cleared.
- R8: If a timer read happens while the active shift differs from the written shift, the counter is shifted left by the difference with ones filled into the low bits. The active shift takes the written value, and no decrement happens that cycle.
- R9: A status read (`rdEn`, `addr[2]` and `addr[0]` set) returns the flag in bit 7 and zeros elsewhere, and does not clear the flag. A read with `addr[2]` clear, and `rdData` with no read, give 0xFF.
- R10: `irq` is high exactly while the flag is set and the interrupt enable is set.
- R11: If a timer read without a shift change meets a pass through zero in the same cycle, the flag ends set.
- R12: When `wrEn` and `rdEn` are both high on a timer access, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address; bits select register, shift and enable |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data (start count) |
| rdData | output | 8 | Read data, combinational from address and state |
| irq | output | 1 | Interrupt request |

## Verification
The countdown is timed at each of the four ratios with a start count of two, and once with a start count of zero. This separates the four shift encodings from each other and catches an off-by-one on the edge that sets the flag. Directed sequences cover the following:
- reading after expiry, which shows the shift restore and the skipped decrement;
- a second full wrap at divide-by-one;
- a read colliding with expiry;
- a masked interrupt.

Random bus traffic with mixed addresses, strobes and data is then compared cycle by cycle against a bench model. This exposes decode mistakes, such as write bits 4 and 2 and read bit 0, that the directed cases touch only once.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;

  typedef struct packed {
    logic       load;       // timer write this cycle
    logic [1:0] sel;        // prescale select from the address
    logic       timerRead;  // timer read this cycle (no write)
  } tmrStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_TIMER  = 2'd1,
    RD_STATUS = 2'd2
  } rdSel_t;

endpackage

// File: rtl/tickTimerCtrl.sv
module tickTimerCtrl
  import tickTimerPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              underflow,
  output tmrStrobes_t       strobes,
  output rdSel_t            rdSel,
  output logic              timerFlag,
  output logic              irq
);

  logic timerWrite;
  logic timerRead;
  logic irqEnable;

  assign timerWrite = wrEn & addr[2] & addr[4];
  assign timerRead  = rdEn & addr[2] & ~addr[0] & ~timerWrite;

  always_comb begin
    strobes.load      = timerWrite;
    strobes.sel       = addr[1:0];
    strobes.timerRead = timerRead;
  end

  always_comb begin
    if (!rdEn || !addr[2]) rdSel = RD_NONE;
    else if (addr[0])      rdSel = RD_STATUS;
    else                   rdSel = RD_TIMER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnable <= 1'b0;
      timerFlag <= 1'b0;
    end else begin
      if (timerWrite || timerRead) irqEnable <= addr[3];
      if (underflow)                        timerFlag <= 1'b1;
      else if (timerWrite || timerRead)     timerFlag <= 1'b0;
    end
  end

  assign irq = timerFlag & irqEnable;

endmodule

// File: rtl/tickTimerDatapath.sv
module tickTimerDatapath
  import tickTimerPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int SHIFT_1 = 3,
  parameter int SHIFT_2 = 6,
  parameter int SHIFT_3 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] readCount,
  output logic              underflow
);

  localparam int CNT_W = DATA_W + SHIFT_3;

  logic [CNT_W-1:0]   count;
  logic [SHIFT_W-1:0] activeShift;
  logic [SHIFT_W-1:0] writtenShift;
  logic [SHIFT_W-1:0] selShift;
  logic [SHIFT_W-1:0] gap;
  logic               restore;

  always_comb begin
    unique case (strobes.sel)
      2'd0:    selShift = '0;
      2'd1:    selShift = SHIFT_W'(SHIFT_1);
      2'd2:    selShift = SHIFT_W'(SHIFT_2);
      default: selShift = SHIFT_W'(SHIFT_3);
    endcase
  end

  assign gap       = writtenShift - activeShift;
  assign restore   = strobes.timerRead & (activeShift != writtenShift);
  assign underflow = ~strobes.load & ~restore & (count == '0);
  assign readCount = DATA_W'(count >> activeShift);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '1;
      activeShift  <= SHIFT_W'(SHIFT_3);
      writtenShift <= SHIFT_W'(SHIFT_3);
    end else if (strobes.load) begin
      count        <= CNT_W'(wrData) << selShift;
      activeShift  <= selShift;
      writtenShift <= selShift;
    end else if (restore) begin
      count       <= (count << gap) | ((CNT_W'(1) << gap) - CNT_W'(1));
      activeShift <= writtenShift;
    end else if (underflow) begin
      count       <= CNT_W'({DATA_W{1'b1}});
      activeShift <= '0;
    end else begin
      count <= count - CNT_W'(1);
    end
  end

endmodule

// File: rtl/tickTimer.sv
module tickTimer
  import tickTimerPkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int SHIFT_1 = 3,
  parameter int SHIFT_2 = 6,
  parameter int SHIFT_3 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  tmrStrobes_t       strobes;
  rdSel_t            rdSel;
  logic              timerFlag;
  logic              underflow;
  logic [DATA_W-1:0] readCount;

  tickTimerCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .underflow(underflow), .strobes(strobes), .rdSel(rdSel),
    .timerFlag(timerFlag), .irq(irq)
  );

  tickTimerDatapath #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W),
    .SHIFT_1(SHIFT_1), .SHIFT_2(SHIFT_2), .SHIFT_3(SHIFT_3)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .readCount(readCount), .underflow(underflow)
  );

  always_comb begin
    unique case (rdSel)
      RD_TIMER:  rdData = readCount;
      RD_STATUS: rdData = {timerFlag, {(DATA_W-1){1'b0}}};
      default:   rdData = '1;
    endcase
  end

endmodule

// File: rtl/tickTimerChecker.sv
module tickTimerChecker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input logic              timerFlag,
  input logic              underflow
);

  logic tWrite, tRead, sRead;
  assign tWrite = wrEn & addr[2] & addr[4];
  assign tRead  = rdEn & addr[2] & ~addr[0] & ~tWrite;
  assign sRead  = rdEn & addr[2] & addr[0];

  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerFlag) |-> $past(underflow));

  assert_underflow_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> timerFlag);

  assert_zero_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tWrite && wrData == '0) ##1 (!wrEn && !rdEn) |-> underflow);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    tWrite |=> !irq);

  assert_status_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (timerFlag && sRead && !wrEn) |=> timerFlag);

  assert_masked_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tRead && !addr[3]) |=> !irq);

endmodule

bind tickTimer tickTimerChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tickTimerChecker (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .irq(irq), .timerFlag(timerFlag), .underflow(underflow)
);

// File: tb/test_tickTimer.sv
module test_tickTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq;

  always #10 clk = ~clk;

  tickTimer i_tickTimer (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Bench model of the requirements
  logic [17:0] mCnt;
  int          mAct, mWr;
  bit          mFlag, mEn;

  function automatic int shiftOf(logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 3;
      2'd2: return 6;
      default: return 10;
    endcase
  endfunction

  function automatic logic [7:0] modelRead(logic [4:0] a, logic r);
    if (!r || !a[2]) return 8'hFF;
    if (a[0]) return {mFlag, 7'b0};
    return 8'(mCnt >> mAct);
  endfunction

  task automatic modelStep(logic [4:0] a, logic w, logic r, logic [7:0] d);
    bit tw, tr;
    tw = w && a[2] && a[4];
    tr = r && a[2] && !a[0] && !tw;
    if (tw) begin
      mAct = shiftOf(a[1:0]); mWr = mAct;
      mCnt = 18'(d) << mAct; mEn = a[3]; mFlag = 1'b0;
    end else begin
      if (tr) begin mEn = a[3]; mFlag = 1'b0; end
      if (tr && mAct != mWr) begin
        mCnt = (mCnt << (mWr - mAct)) | ((18'd1 << (mWr - mAct)) - 18'd1);
        mAct = mWr;
      end else if (mCnt == '0) begin
        mCnt = 18'hFF; mAct = 0; mFlag = 1'b1;
      end else begin
        mCnt = mCnt - 18'd1;
      end
    end
  endtask

  task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic checkInt(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare before the edge, advance model.
  task automatic step(logic [4:0] a, logic w, logic r, logic [7:0] d,
                      string tag, output logic [7:0] seen);
    addr = a; wrEn = w; rdEn = r; wrData = d;
    #1;
    seen = rdData;
    check8({tag, " rdData vs model"}, rdData, modelRead(a, r));
    checkInt({tag, " irq vs model"}, int'(irq), int'(mFlag && mEn));
    @(posedge clk);
    modelStep(a, w, r, d);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    logic [7:0] s;
    step(5'b00000, 1'b0, 1'b0, 8'h00, tag, s);
  endtask

  task automatic measure(logic [1:0] sel, logic [7:0] n);
    logic [7:0] s;
    int k;
    step({3'b111, sel}, 1'b1, 1'b0, n, "R2 write", s);
    k = 0;
    while (irq !== 1'b1 && k < 5000) begin
      idle("R4 countdown");
      k++;
    end
    checkInt($sformatf("R5 clocks to flag sel=%0d n=%0d", sel, n), k,
             (int'(n) << shiftOf(sel)) + 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'd20240611));
    mCnt = '1; mAct = 10; mWr = 10; mFlag = 1'b0; mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(5'b00101, 1'b0, 1'b1, 8'h00, "R1", s); check8("R1 status", s, 8'h00);
    checkInt("R1 irq", int'(irq), 0);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R1", s); check8("R1 timer", s, 8'hFF);

    // R2 loads at each shift, R3 ignored writes
    step(5'b10110, 1'b1, 1'b0, 8'h5A, "R2", s);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R2", s); check8("R2 readback /64", s, 8'h5A);
    step(5'b00110, 1'b1, 1'b0, 8'h11, "R3", s);
    step(5'b10010, 1'b1, 1'b0, 8'h22, "R3", s);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R3", s); check8("R3 ignored writes", s, 8'h59);
    step(5'b10111, 1'b1, 1'b0, 8'h33, "R2", s);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R2", s); check8("R2 readback /1024", s, 8'h33);
    step(5'b10100, 1'b1, 1'b0, 8'h40, "R2", s);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R2", s); check8("R2 readback /1", s, 8'h40);

    // R5 timing at every prescale
    measure(2'd0, 8'd2);
    measure(2'd1, 8'd2);
    measure(2'd2, 8'd2);
    measure(2'd3, 8'd2);
    measure(2'd3, 8'd0);

    // R6 count after expiry, R8 restore on read, R7 clear
    repeat (5) idle("R6");
    step(5'b01100, 1'b0, 1'b1, 8'h00, "R8", s); check8("R6 after-expiry count", s, 8'hFA);
    checkInt("R7 read clears flag", int'(irq), 0);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R8", s); check8("R8 restored no decrement", s, 8'hFA);

    // R6 second wrap at divide-by-one
    step(5'b11100, 1'b1, 1'b0, 8'h00, "R6", s);
    idle("R6");
    checkInt("R6 first expiry", int'(irq), 1);
    step(5'b01100, 1'b0, 1'b1, 8'h00, "R6", s); check8("R6 reload 0xFF", s, 8'hFF);
    repeat (254) idle("R4");
    checkInt("R4 zero without flag", int'(irq), 0);
    idle("R6");
    checkInt("R6 second expiry", int'(irq), 1);
    step(5'b01100, 1'b0, 1'b1, 8'h00, "R6", s); check8("R6 wrapped to 0xFF", s, 8'hFF);

    // R11 read meets expiry
    step(5'b11100, 1'b1, 1'b0, 8'h00, "R11", s);
    step(5'b01100, 1'b0, 1'b1, 8'h00, "R11", s); check8("R11 read value", s, 8'h00);
    checkInt("R11 flag wins", int'(irq), 1);

    // R9 status read keeps flag, undecoded read
    step(5'b00101, 1'b0, 1'b1, 8'h00, "R9", s); check8("R9 status", s, 8'h80);
    checkInt("R9 flag kept", int'(irq), 1);
    step(5'b00000, 1'b0, 1'b1, 8'h00, "R9", s); check8("R9 undecoded read", s, 8'hFF);

    // R10 masked interrupt
    step(5'b10100, 1'b1, 1'b0, 8'h00, "R10", s);
    idle("R10");
    checkInt("R10 masked irq", int'(irq), 0);
    step(5'b00111, 1'b0, 1'b1, 8'h00, "R10", s); check8("R10 flag visible", s, 8'h80);

    // R12 write and read together
    step(5'b11101, 1'b1, 1'b1, 8'h07, "R12", s);
    step(5'b00100, 1'b0, 1'b1, 8'h00, "R12", s); check8("R12 write wins", s, 8'h07);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic w, r;
      logic [7:0] d;
      a = 5'($urandom);
      w = ($urandom % 6) == 0;
      r = !w && (($urandom % 3) == 0);
      d = 8'($urandom % 24);
      step(a, w, r, d, "R7 R11 random", s);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule